// File: doc/BRIEF.md
# Byte-Wide Asynchronous Serial Port

This block is an asynchronous serial port for a microcontroller's peripheral space. It moves single bytes in 8N1 frames: one low start bit, eight data bits least significant first, and one high stop bit. Software works it through four byte registers on a small address/data bus with read and write strobes.

- **Rate/mode register.** Picks the bit rate.
- **Control/status register.** Holds the enables and the two status flags.
- **Receive data register.** Read-only; returns the last byte taken in.
- **Transmit data register.** Write-only; starts a frame.

A received byte is held until software releases it in a fixed way: first a read of the control/status register that sees the byte waiting, then a read of the receive data register. Any frame that completes before that release is thrown away. The interrupt output combines the receive-full and transmit-empty conditions, each with its own enable.

The bus has no back-pressure. Every strobe completes in the cycle it is sampled, and read data is combinational from the address. The serial lines are plain pins: `rxd` is sampled asynchronously, and `txd` is qualified by `txd_oe`.

Top module: `sio_port`

## Requirements
- R1: After reset the control/status register (offset 1) reads 0x20: transmit-empty (bit 5) is 1 and every other bit is 0. The rate register (offset 0) reads 0, `irq` is 0, `txd` is 1 and `txd_oe` is 0.
- R2: The rate register keeps bits 3:0 and reads 0 in bits 7:4. In the control/status register, bits 4 (receive interrupt enable), 3 (receive enable), 2 (transmit interrupt enable) and 1 (transmit enable) are writable; writes to bits 7, 6, 5 and 0 have no effect. Offset 3 reads as 0.
- R3: When transmit-empty is 1, a write to offset 3 clears it. With transmit enable set, `txd_oe` is 1 and `txd` then carries a start bit of 0, the eight data bits LSB first, and a stop bit of 1. Transmit-empty returns to 1 after the stop bit.
- R4: A write to offset 3 while transmit-empty is 0 is ignored. While transmit enable is 0, `txd` stays 1 and `txd_oe` stays 0, and a written byte waits until transmit enable is set.
- R5: With receive enable set, a valid 8N1 frame on `rxd` sets receive-full (bit 7), and the byte reads back at offset 2.
- R6: Receive-full clears only after a read of offset 1 that sees it set, followed by a read of offset 2. A read of offset 2 on its own leaves it set.
- R7: While receive-full is set, frames that arrive are dropped, and offset 2 keeps the first byte.
- R8: A frame whose stop bit samples 0 is discarded and leaves receive-full at 0. The receiver then waits for the line to return high before looking for a new start bit.
- R9: While receive enable is 0, activity on `rxd` does not set receive-full.
- R10: `irq` is 1 exactly when (receive-full and bit 4) or (transmit-empty and bit 2).
- R11: Rate bits 1:0 select a bit period of 16·8^sel clock cycles: 16, 128, 1024 or 8192. Setting 1 gives 7812.5 baud from a 1 MHz clock. Bits 3:2 are stored and read back only.
- R12: Reception and transmission run independently. A frame received while a frame is being sent leaves both flags set and the received byte intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; side effects act at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| rxd | input | 1 | Serial receive line, asynchronous |
| txd | output | 1 | Serial transmit line, idle high |
| txd_oe | output | 1 | High while the transmit line is driven |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two activities can finish in the same clock: a frame completing at the receiver, and a frame finishing at the transmitter. They share the tick generator and the interrupt output, but nothing else. The bench provokes the collision by writing the transmit register and, in the next cycle, starting a frame on `rxd` at the same rate, so both finish within a few cycles of each other. The run passes only if afterwards the status reads with both bit 7 and bit 5 set, the received byte is unchanged, and the transmitted frame decodes bit for bit.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DATA_W = 8;
  localparam int OVERSAMPLE = 16;

  typedef enum logic [1:0] {
    REG_RATE = 2'd0,
    REG_CTRL = 2'd1,
    REG_RXD  = 2'd2,
    REG_TXD  = 2'd3
  } reg_addr_e;

  localparam int BIT_RXFULL = 7;
  localparam int BIT_TXEMPTY = 5;
  localparam int BIT_RXIE = 4;
  localparam int BIT_RXEN = 3;
  localparam int BIT_TXIE = 2;
  localparam int BIT_TXEN = 1;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rx_state_e;
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int CNT_W = 12,
  parameter int STEP = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  output logic       tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim = (CNT_W'(1) << (STEP * int'(rate_sel))) - CNT_W'(1);
    tick = (cnt >= lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int DATA_W = 8,
  parameter int OS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output logic              line,
  output logic              busy,
  output logic              done
);
  localparam int FRAME = DATA_W + 2;
  localparam int TC_W = $clog2(OS);
  localparam int BC_W = $clog2(FRAME);

  logic [FRAME-1:0] shreg;
  logic [TC_W-1:0]  tcnt;
  logic [BC_W-1:0]  bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      tcnt  <= '0;
      bcnt  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          shreg <= {1'b1, data, 1'b0};
          tcnt  <= '0;
          bcnt  <= '0;
          busy  <= 1'b1;
        end
      end else if (tick) begin
        if (tcnt == TC_W'(OS - 1)) begin
          tcnt  <= '0;
          shreg <= {1'b1, shreg[FRAME-1:1]};
          if (bcnt == BC_W'(FRAME - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bcnt <= bcnt + BC_W'(1);
          end
        end else begin
          tcnt <= tcnt + TC_W'(1);
        end
      end
    end
  end

  assign line = busy ? shreg[0] : 1'b1;

  AST_TX_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_TX_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R3
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] data
);
  localparam int TC_W = $clog2(OS);
  localparam int BC_W = $clog2(DATA_W);

  logic [1:0]      sync;
  logic            rx_s;
  rx_state_e       state;
  logic [TC_W-1:0] tcnt;
  logic [BC_W-1:0] bcnt;

  assign rx_s = sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      tcnt  <= '0;
      bcnt  <= '0;
      data  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        state <= RX_IDLE;
      end else if (tick) begin
        unique case (state)
          RX_IDLE: begin
            if (!rx_s) begin
              state <= RX_START;
              tcnt  <= '0;
            end
          end
          RX_START: begin
            if (tcnt == TC_W'(OS / 2 - 1)) begin
              tcnt  <= '0;
              bcnt  <= '0;
              state <= rx_s ? RX_IDLE : RX_DATA;
            end else begin
              tcnt <= tcnt + TC_W'(1);
            end
          end
          RX_DATA: begin
            if (tcnt == TC_W'(OS - 1)) begin
              tcnt <= '0;
              data <= {rx_s, data[DATA_W-1:1]};
              if (bcnt == BC_W'(DATA_W - 1)) state <= RX_STOP;
              else bcnt <= bcnt + BC_W'(1);
            end else begin
              tcnt <= tcnt + TC_W'(1);
            end
          end
          RX_STOP: begin
            if (tcnt == TC_W'(OS - 1)) begin
              tcnt <= '0;
              if (rx_s) begin
                done  <= 1'b1;
                state <= RX_IDLE;
              end else begin
                state <= RX_BREAK;
              end
            end else begin
              tcnt <= tcnt + TC_W'(1);
            end
          end
          RX_BREAK: begin
            if (rx_s) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  AST_RX_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !done); // R9
  AST_RX_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state) == RX_STOP); // R5
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int BAUD_CNT_W = 12,
  parameter int BAUD_STEP = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       txd_oe,
  output logic       irq
);
  localparam logic [7:0] CTRL_WMASK = 8'((1 << BIT_RXIE) | (1 << BIT_RXEN) |
                                         (1 << BIT_TXIE) | (1 << BIT_TXEN));

  logic [3:0]        rate_q;
  logic [7:0]        ctrl_q;
  logic              rx_full;
  logic              rd_armed;
  logic              tx_empty;
  logic              tx_pend;
  logic [DATA_W-1:0] rx_buf;
  logic [DATA_W-1:0] tx_hold;
  logic              tick;
  logic              tx_line, tx_busy, tx_done, tx_start;
  logic              rx_done;
  logic [DATA_W-1:0] rx_word;
  logic              te, re;
  logic [7:0]        status;
  logic              wr_rate, wr_ctrl, wr_txd, rd_ctrl, rd_rxd;

  assign te = ctrl_q[BIT_TXEN];
  assign re = ctrl_q[BIT_RXEN];
  assign wr_rate = bus_wr && (bus_addr == REG_RATE);
  assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
  assign wr_txd  = bus_wr && (bus_addr == REG_TXD);
  assign rd_ctrl = bus_rd && (bus_addr == REG_CTRL);
  assign rd_rxd  = bus_rd && (bus_addr == REG_RXD);

  sio_baud #(.CNT_W(BAUD_CNT_W), .STEP(BAUD_STEP)) i_baud (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_q[1:0]), .tick(tick)
  );

  sio_tx #(.DATA_W(DATA_W), .OS(OVERSAMPLE)) i_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(tx_start), .data(tx_hold),
    .line(tx_line), .busy(tx_busy), .done(tx_done)
  );

  sio_rx #(.DATA_W(DATA_W), .OS(OVERSAMPLE)) i_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(re), .rxd(rxd),
    .done(rx_done), .data(rx_word)
  );

  assign tx_start = te && tx_pend && !tx_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_rate) rate_q <= bus_wdata[3:0];
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_WMASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty <= 1'b1;
      tx_pend  <= 1'b0;
      tx_hold  <= '0;
    end else begin
      if (wr_txd && tx_empty) begin
        tx_hold  <= bus_wdata;
        tx_pend  <= 1'b1;
        tx_empty <= 1'b0;
      end else begin
        if (tx_start) tx_pend <= 1'b0;
        if (tx_done) tx_empty <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full  <= 1'b0;
      rd_armed <= 1'b0;
      rx_buf   <= '0;
    end else begin
      if (rx_full && rd_armed && rd_rxd) begin
        rx_full  <= 1'b0;
        rd_armed <= 1'b0;
      end else begin
        if (rd_ctrl && rx_full) rd_armed <= 1'b1;
        if (rx_done && !rx_full) begin
          rx_full <= 1'b1;
          rx_buf  <= rx_word;
        end
      end
    end
  end

  always_comb begin
    status = ctrl_q;
    status[BIT_RXFULL]  = rx_full;
    status[BIT_TXEMPTY] = tx_empty;
    unique case (bus_addr)
      REG_RATE: bus_rdata = {4'b0, rate_q};
      REG_CTRL: bus_rdata = status;
      REG_RXD:  bus_rdata = rx_buf;
      default:  bus_rdata = '0;
    endcase
  end

  assign txd    = te ? tx_line : 1'b1;
  assign txd_oe = te;
  assign irq    = (rx_full && ctrl_q[BIT_RXIE]) || (tx_empty && ctrl_q[BIT_TXIE]);

  AST_RXFULL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_done)); // R5
  AST_RXFULL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(rd_armed && bus_rd && bus_addr == REG_RXD)); // R6
  AST_RXBUF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && $past(rx_full)) |-> $stable(rx_buf)); // R7
  AST_TXEMPTY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $past(tx_done)); // R3
  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd); // R4
  AST_TXE_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !tx_empty); // R4
endmodule

// File: tb/test_sio_port.sv
module test_sio_port;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rxd = 1'b1;
  logic       txd, txd_oe, irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  sio_port i_sio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd), .txd_oe(txd_oe), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, act=%0d exp<=%0d cycles", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0] rate;
    logic [7:0] data;
    logic       stop;
    logic [7:0] exp_stat;
    logic [7:0] exp_data;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 8'h00, 1'b1, 8'hA8, 8'h00},
    '{2'd0, 8'hFF, 1'b1, 8'hA8, 8'hFF},
    '{2'd0, 8'hA5, 1'b1, 8'hA8, 8'hA5},
    '{2'd0, 8'h5A, 1'b0, 8'h28, 8'h00},
    '{2'd1, 8'h01, 1'b1, 8'hA8, 8'h01},
    '{2'd1, 8'h80, 1'b1, 8'hA8, 8'h80},
    '{2'd0, 8'h3C, 1'b1, 8'hA8, 8'h3C}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic expect_rd(input logic [1:0] a, input logic [7:0] e, input string req);
    logic [7:0] v;
    rd(a, v);
    check(v === e, req, v, e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop, input int bitclk);
    @(negedge clk);
    rxd = 1'b0;
    idle(bitclk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      idle(bitclk);
    end
    rxd = stop;
    idle(bitclk);
    rxd = 1'b1;
    idle(bitclk);
  endtask

  task automatic grab_tx(input int bitclk, output logic [7:0] b, output logic framing_ok);
    int n;
    n = 0;
    while (txd !== 1'b0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    idle(bitclk / 2);
    framing_ok = (txd === 1'b0);
    for (int i = 0; i < 8; i++) begin
      idle(bitclk);
      b[i] = txd;
    end
    idle(bitclk);
    framing_ok = framing_ok && (txd === 1'b1);
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] tb;
    logic       fok;
    bit         quiet;

    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    expect_rd(2'd1, 8'h20, "R1 status");
    expect_rd(2'd0, 8'h00, "R1 rate");
    check(irq === 1'b0 && txd === 1'b1 && txd_oe === 1'b0, "R1 pins",
          {irq, txd, txd_oe}, 3'b010);

    // R2 writable fields
    wr(2'd0, 8'hFF);
    expect_rd(2'd0, 8'h0F, "R2 rate mask");
    wr(2'd1, 8'hFF);
    expect_rd(2'd1, 8'h3E, "R2 ctrl mask");
    expect_rd(2'd3, 8'h00, "R2 txd readback");
    // R10 transmit-empty with its enable
    check(irq === 1'b1, "R10 irq tx", irq, 1);
    wr(2'd1, 8'h00);
    check(irq === 1'b0, "R10 irq masked", irq, 0);

    // table: R5 R8 R11
    wr(2'd1, 8'h08);
    for (int k = 0; k < NVEC; k++) begin
      wr(2'd0, {6'b0, VEC[k].rate});
      send_rx(VEC[k].data, VEC[k].stop, 16 << (3 * VEC[k].rate));
      expect_rd(2'd1, VEC[k].exp_stat, "R5 R8 R11 table status");
      if (VEC[k].exp_stat[7]) begin
        expect_rd(2'd2, VEC[k].exp_data, "R5 R11 table data");
        expect_rd(2'd1, 8'h28, "R6 table release");
      end
    end
    wr(2'd0, 8'h00);

    // R6 data read alone keeps the flag
    send_rx(8'h6E, 1'b1, 16);
    expect_rd(2'd2, 8'h6E, "R6 data");
    expect_rd(2'd1, 8'hA8, "R6 still full");
    expect_rd(2'd2, 8'h6E, "R6 data 2");
    expect_rd(2'd1, 8'h28, "R6 released");

    // R7 drop while full, R10 receive interrupt
    wr(2'd1, 8'h18);
    send_rx(8'h11, 1'b1, 16);
    check(irq === 1'b1, "R10 irq rx", irq, 1);
    send_rx(8'h22, 1'b1, 16);
    expect_rd(2'd1, 8'hB8, "R7 status");
    expect_rd(2'd2, 8'h11, "R7 first kept");
    check(irq === 1'b0, "R10 irq cleared", irq, 0);
    expect_rd(2'd1, 8'h38, "R7 second dropped");

    // R9 receiver disabled
    wr(2'd1, 8'h00);
    send_rx(8'h77, 1'b1, 16);
    expect_rd(2'd1, 8'h20, "R9 ignored");

    // R3 transmit
    wr(2'd1, 8'h02);
    wr(2'd3, 8'hC3);
    expect_rd(2'd1, 8'h02, "R3 empty cleared");
    check(txd_oe === 1'b1, "R3 oe", txd_oe, 1);
    grab_tx(16, tb, fok);
    check(tb === 8'hC3 && fok, "R3 frame", tb, 8'hC3);
    idle(20);
    expect_rd(2'd1, 8'h22, "R3 empty set");

    // R4 write while busy ignored
    wr(2'd3, 8'h4B);
    wr(2'd3, 8'hE1);
    grab_tx(16, tb, fok);
    check(tb === 8'h4B && fok, "R4 first frame", tb, 8'h4B);
    quiet = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) quiet = 1'b0;
    end
    check(quiet, "R4 no second frame", quiet, 1);
    expect_rd(2'd1, 8'h22, "R4 empty");

    // R4 transmit disabled holds byte
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h96);
    quiet = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || txd_oe !== 1'b0) quiet = 1'b0;
    end
    check(quiet, "R4 line idle", quiet, 1);
    expect_rd(2'd1, 8'h00, "R4 pending");
    wr(2'd1, 8'h02);
    grab_tx(16, tb, fok);
    check(tb === 8'h96 && fok, "R4 released frame", tb, 8'h96);

    // R11 transmit at rate 1
    idle(40);
    wr(2'd0, 8'h01);
    wr(2'd3, 8'hA9);
    grab_tx(128, tb, fok);
    check(tb === 8'hA9 && fok, "R11 tx 128", tb, 8'hA9);
    idle(200);
    wr(2'd0, 8'h00);

    // R12 both directions together
    wr(2'd1, 8'h0A);
    wr(2'd3, 8'h5D);
    fork
      send_rx(8'hE7, 1'b1, 16);
      grab_tx(16, tb, fok);
    join
    idle(20);
    check(tb === 8'h5D && fok, "R12 tx frame", tb, 8'h5D);
    expect_rd(2'd1, 8'hAA, "R12 both flags");
    expect_rd(2'd2, 8'hE7, "R12 rx data");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule